// File: doc/BRIEF.md
# Loss-of-Timing Guard with Data Squelch and Cycling Alarm

This block watches a channel's timing pulse stream with a retriggerable timeout. Each detected timing pulse restarts the timeout. While the pulses keep coming, the data beats on the stream interface pass through unchanged. If no pulse is detected for `TIMEOUT_CYC` clock cycles, the guard enters the expired state. In that state it forces every outgoing data beat to all zeros and raises the out-of-tolerance line. The timing pulse is asynchronous. It passes through two synchronizing flops, and its rising edge is then extracted before it touches the timeout.

A second source drives the same out-of-tolerance line. While an upstream decoder holds its request high, a square-wave generator produces a slow waveform with a 50% duty cycle. The waveform is high for `HALF_PERIOD_CYC` cycles and then low for `HALF_PERIOD_CYC` cycles. Scaled to the system clock, the full period is about 31 seconds. The generator output and the expired state are ORed onto the single alarm output that feeds a display.

The data path is a valid/ready pass-through with no storage. `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle. A beat moves when both `in_valid` and `out_ready` are high. Back-pressure from downstream reaches the source without delay and is never absorbed. The handshake continues while the data is squelched; only the data value is replaced by zero.

Top module: `timing_loss_guard`

## Requirements
- R1: After reset the guard is expired: `out_data` is all zeros and `oot_alarm` is high until the first timing pulse is detected.
- R2: A rising edge of `timing_in` first sampled at clock edge n clears the expired state at edge n+2. Data passes after that edge.
- R3: Pulses whose detection edges are at most `TIMEOUT_CYC` edges apart never let the guard expire.
- R4: The guard becomes expired `TIMEOUT_CYC` edges after the last detection edge. While expired, `out_data` is all zeros.
- R5: `oot_alarm` is high in every cycle in which the guard is expired.
- R6: Let `ot_req` first be sampled high at edge a and stay high. After edge e ≥ a, the cycling wave is high when floor((e−a)/`HALF_PERIOD_CYC`) is even and low when it is odd.
- R7: The cycling wave is low after the first edge at which `ot_req` is sampled low.
- R8: `oot_alarm` equals the OR of the expired state and the cycling wave.
- R9: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle, whether or not the data is squelched.
- R10: When the guard is not expired, `out_data` equals `in_data` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_in | input | 1 | Incoming channel timing pulse (asynchronous) |
| ot_req | input | 1 | Out-of-tolerance request from the decoder (synchronous) |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Upstream ready, equal to `out_ready` |
| in_data | input | DATA_W | Upstream data |
| out_valid | output | 1 | Downstream beat valid, equal to `in_valid` |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Data out, all zeros while expired |
| oot_alarm | output | 1 | Out-of-tolerance line to the display |

## Verification
Each result has a fixed due cycle. The handshake and the data mux are combinational, so they are due in the same cycle as their inputs. A timing rise sampled at edge n takes effect at edge n+2. Expiry lands exactly `TIMEOUT_CYC` edges after the detection edge. The cycling wave toggles every `HALF_PERIOD_CYC` edges counted from the first edge that samples the request. It drops one edge after the request is sampled low. The bench counts rising edges itself and records the edge that sampled each timing rise and each request start. It derives every expected level from these edge numbers alone. It drives inputs 3 ns after each rising edge and checks the outputs before the next edge, so every check sees the state after exactly one known edge.

// File: rtl/tlg_pkg.sv
package tlg_pkg;
  // Counter width for counting 0..n-1, at least one bit.
  function automatic int cnt_w(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

  typedef enum logic {
    WD_LIVE    = 1'b0,
    WD_EXPIRED = 1'b1
  } wd_state_e;
endpackage

// File: rtl/tlg_edge_sync.sv
module tlg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];

  assign rise_pulse = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tlg_watchdog.sv
module tlg_watchdog
  import tlg_pkg::*;
#(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic expired
);
  localparam int CW = cnt_w(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  wd_state_e     state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_EXPIRED;
      cnt_q   <= '0;
    end else if (kick) begin
      state_q <= WD_LIVE;
      cnt_q   <= '0;
    end else if (state_q == WD_LIVE) begin
      if (cnt_q == LAST) begin
        state_q <= WD_EXPIRED;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign expired = (state_q == WD_EXPIRED);
endmodule

// File: rtl/tlg_cycler.sv
module tlg_cycler
  import tlg_pkg::*;
#(
  parameter int HALF_PERIOD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic wave
);
  localparam int CW = cnt_w(HALF_PERIOD_CYC);
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD_CYC - 1);

  logic          active_q;
  logic          phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b1;
      cnt_q    <= '0;
    end else if (!req) begin
      active_q <= 1'b0;
      phase_q  <= 1'b1;
      cnt_q    <= '0;
    end else begin
      active_q <= 1'b1;
      if (active_q) begin
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          phase_q <= ~phase_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign wave = active_q & phase_q;
endmodule

// File: rtl/timing_loss_guard.sv
module timing_loss_guard #(
  parameter int DATA_W          = 8,
  parameter int TIMEOUT_CYC     = 1024,
  parameter int HALF_PERIOD_CYC = 1937500000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              timing_in,
  input  logic              ot_req,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              oot_alarm
);
  logic timing_rise;
  logic wd_expired;
  logic cyc_wave;

  tlg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_in   (timing_in),
    .rise_pulse (timing_rise)
  );

  tlg_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .kick    (timing_rise),
    .expired (wd_expired)
  );

  tlg_cycler #(.HALF_PERIOD_CYC(HALF_PERIOD_CYC)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (ot_req),
    .wave  (cyc_wave)
  );

  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign out_data  = wd_expired ? '0 : in_data;
  assign oot_alarm = wd_expired | cyc_wave;
endmodule

// File: rtl/timing_loss_guard_chk.sv
module timing_loss_guard_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ot_req,
  input logic [DATA_W-1:0] in_data,
  input logic [DATA_W-1:0] out_data,
  input logic              oot_alarm,
  input logic              timing_rise,
  input logic              wd_expired,
  input logic              cyc_wave
);
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    timing_rise |=> !wd_expired); // R2
  AST_EXPIRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_expired && !timing_rise) |=> wd_expired); // R4
  AST_SQUELCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expired |-> (out_data == '0)); // R4
  AST_ALARM_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expired |-> oot_alarm); // R5
  AST_WAVE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !ot_req |=> !cyc_wave); // R7
  AST_ALARM_ON_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wave |-> oot_alarm); // R8
  AST_PASS_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !oot_alarm |-> (out_data == in_data)); // R10
endmodule

bind timing_loss_guard timing_loss_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ot_req      (ot_req),
  .in_data     (in_data),
  .out_data    (out_data),
  .oot_alarm   (oot_alarm),
  .timing_rise (timing_rise),
  .wd_expired  (wd_expired),
  .cyc_wave    (cyc_wave)
);

// File: tb/timing_loss_guard_tb.sv
`timescale 1ns/1ps
module timing_loss_guard_tb;
  localparam int DW = 8;
  localparam int TO = 12;
  localparam int HP = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          timing_in = 1'b0;
  logic          ot_req = 1'b0;
  logic          in_valid = 1'b0;
  logic          out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, out_valid, oot_alarm;
  logic [DW-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  timing_loss_guard #(.DATA_W(DW), .TIMEOUT_CYC(TO), .HALF_PERIOD_CYC(HP)) u_dut (
    .clk(clk), .rst_n(rst_n), .timing_in(timing_in), .ot_req(ot_req),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .oot_alarm(oot_alarm)
  );

  // Edge-numbered reference bookkeeping
  int e = 0;
  int r_last = -1000;
  int r_prev = -1000;
  bit prev_t = 0;
  bit act = 0;
  int a_edge = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      e = 0; r_last = -1000; r_prev = -1000; prev_t = 0; act = 0;
    end else begin
      e = e + 1;
      if (timing_in && !prev_t) begin r_prev = r_last; r_last = e; end
      prev_t = timing_in;
      if (ot_req) begin
        if (!act) begin act = 1; a_edge = e; end
      end else act = 0;
    end
  end

  function automatic bit exp_sq();
    int c;
    c = (r_last + 2 <= e) ? r_last + 2 : r_prev + 2;
    return !(c > 0 && (e - c) < TO);
  endfunction

  function automatic bit exp_wave();
    return act && ((((e - a_edge) / HP) % 2) == 0);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] want);
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s edge %0d: actual %0h expected %0h", req, e, got, want);
    end
  endtask

  task automatic cyc(input bit t, input bit r);
    bit sq, wv;
    @(posedge clk); #3;
    sq = exp_sq();
    wv = exp_wave();
    chk(sq ? (tag == "R1" ? "R1" : "R4") : "R10", out_data, sq ? 0 : in_data);
    chk(sq ? (tag == "R1" ? "R1" : "R5") : tag, oot_alarm, sq | wv);
    chk("R8", oot_alarm, sq | wv);
    chk("R9", {out_valid, in_ready}, {in_valid, out_ready});
    timing_in = t;
    ot_req    = r;
    in_data   = DW'(e * 37 + 11);
    in_valid  = e[0];
    out_ready = e[1] ^ e[2];
  endtask

  initial begin
    #200000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    // R1: expired from reset, no pulses
    tag = "R1";
    for (int i = 0; i < 6; i++) cyc(0, 0);
    // R2: first pulse, latency checked each cycle
    tag = "R2";
    cyc(1, 0); cyc(1, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0);
    // R3 / R4: sweep pulse spacing across the timeout boundary
    for (int p = 4; p <= TO + 4; p++) begin
      tag = (p <= TO) ? "R3" : "R4";
      for (int k = 0; k < 5; k++) begin
        cyc(1, 0); cyc(1, 0);
        for (int j = 2; j < p; j++) cyc(0, 0);
      end
    end
    tag = "R4";
    for (int i = 0; i < TO + 6; i++) cyc(0, 0);
    // R6 / R7: request hold lengths, timing kept alive then let lapse
    for (int h = 1; h <= 3 * HP + 2; h++) begin
      tag = "R6";
      for (int i = 0; i < h; i++) cyc((i % 4) < 2, 1);
      tag = "R7";
      for (int i = 0; i < 4; i++) cyc(i < 2, 0);
    end
    // R8: wave together with expired guard
    tag = "R8";
    for (int i = 0; i < TO + 2 * HP + 4; i++) cyc(0, 1);
    for (int i = 0; i < 4; i++) cyc(0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule